// File: doc/BRIEF.md
# Timestamped Packet Playback Scheduler

This block replays a stream of stored packets onto one serial output channel. Each packet arrives with a signed timestamp. A free-running cycle counter, which starts at zero when reset is released, sets the pace. When a start trigger arrives, the block takes the packet waiting at the input and computes a start offset from it. The offset is the counter value of the next cycle, minus that packet's timestamp, plus a programmable start delay. With a delay of zero, the first packet leaves in the first playback cycle. Several channels started by the same trigger therefore stay aligned.

During playback a packet passes from the input stream to the output stream once the counter reaches its timestamp plus the offset. Every packet that leaves is counted. When a packet is handed over, the block measures how late it is: the counter minus the scheduled time. That figure includes any cycles lost to output backpressure. A lateness above the programmable threshold sets a sticky error flag and stops playback. Playback also ends on a stop trigger, or when an end-of-stream marker is consumed from the input. A stopped output marks both ending states. A start trigger in either ending state re-arms the block for the next run.

Top module: `pkt_playback_sched`

## Requirements
- R1: After reset the state output is Idle and stopped, error flag, packet count, out_valid and in_ready are all 0.
- R2: In Idle the block moves to Ready in the cycle after in_valid is seen high. No input beat is accepted (in_ready low) while the state is Idle or Ready.
- R3: A start trigger in Ready sets the offset to (counter + 1 − timestamp of the waiting packet + start delay) and enters Generate. With delay D and no backpressure, the first packet is handed over D + 1 cycles after the trigger cycle.
- R4: In Generate, a data beat (in_eos low) is presented with out_valid high and out_data equal to in_data exactly when the signed counter is greater than or equal to its timestamp plus the offset. in_ready then equals out_ready.
- R5: The packet count increases by one for every output handshake (out_valid and out_ready both high) and changes at no other time, except that re-arming clears it.
- R6: At each handshake the lateness is the counter minus the scheduled time. A lateness strictly above the threshold sets the error flag and moves the state to Error in the same clock edge. The flag stays set until the block returns to Idle.
- R7: While out_ready is low the due packet stays presented, and the stalled cycles add to its lateness.
- R8: A beat with in_eos high, met in Generate, is accepted at once without producing output, and the state becomes Done.
- R9: A stop trigger in Ready or Generate moves the state to Done and blocks any handshake in that cycle. The count keeps its value.
- R10: stopped_o is high exactly in Done and Error. A start trigger in either state returns to Idle and clears the count and the error flag.
- R11: The state output uses the encoding Idle = 0, Ready = 1, Generate = 2, Done = 3, Error = 4.
- R12: Timestamps and the start delay are two's-complement signed values, so negative timestamps are scheduled correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start_delay | input | TS_W | Signed cycles added to the start offset |
| cfg_err_thresh | input | TS_W | Largest lateness, in cycles, that is not an error |
| start_trig | input | 1 | Starts playback in Ready; re-arms in Done or Error |
| stop_trig | input | 1 | Ends playback in Ready or Generate |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted |
| in_ts | input | TS_W | Signed timestamp of the input packet |
| in_data | input | DATA_W | Packet payload |
| in_eos | input | 1 | Beat is an end-of-stream marker, not a packet |
| out_valid | output | 1 | Packet released to the channel |
| out_ready | input | 1 | Channel can take the packet |
| out_data | output | DATA_W | Released payload |
| state_o | output | 3 | Current state, encoded as in R11 |
| stopped_o | output | 1 | Playback has ended (Done or Error) |
| pkt_count_o | output | CNT_W | Packets released in this run |
| timing_err_o | output | 1 | Sticky lateness error flag |

## Verification
The bench targets the edges of the release comparison. Two packets share a timestamp; a design that compared with "greater than" alone would hold the second one back a cycle and add lateness to it. The first release after the trigger is timed exactly, with zero delay and with a positive delay. An off-by-one in the offset would show up there as a shifted handover, or as a false timing error. Backpressure is applied once inside and once beyond the threshold. This catches a design that measures lateness at the moment a packet becomes due instead of at the handshake, or one whose error flag fails to stick or stop the run. Stop triggers in Ready and mid-stream, with packets still pending, expose designs that leak a handshake in the stop cycle or that keep the count or flag across a re-arm.

// File: rtl/psched_pkg.sv
`timescale 1ns/1ps
package psched_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READY = 3'd1,
        ST_GEN   = 3'd2,
        ST_DONE  = 3'd3,
        ST_ERR   = 3'd4
    } psched_state_e;

endpackage

// File: rtl/psched_timebase.sv
`timescale 1ns/1ps
module psched_timebase #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] now_o
);

    logic [W-1:0] now_d, now_q;

    always_comb begin
        now_d = now_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_d;
    end

    assign now_o = now_q;

endmodule

// File: rtl/psched_due_eval.sv
`timescale 1ns/1ps
module psched_due_eval #(
    parameter int W = 64
) (
    input  logic [W-1:0] now_i,
    input  logic [W-1:0] ts_i,
    input  logic [W-1:0] offset_i,
    input  logic [W-1:0] thresh_i,
    output logic         due_o,
    output logic         late_o
);

    logic signed [W-1:0] sched_time;
    logic        [W-1:0] lateness;

    always_comb begin
        sched_time = $signed(ts_i) + $signed(offset_i);
        due_o      = $signed(now_i) >= sched_time;
        lateness   = now_i - sched_time;
        late_o     = due_o && (lateness > thresh_i);
    end

endmodule

// File: rtl/pkt_playback_sched.sv
`timescale 1ns/1ps
module pkt_playback_sched
    import psched_pkg::*;
#(
    parameter int TS_W   = 64,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   cfg_start_delay,
    input  logic [TS_W-1:0]   cfg_err_thresh,
    input  logic              start_trig,
    input  logic              stop_trig,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TS_W-1:0]   in_ts,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_eos,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [2:0]        state_o,
    output logic              stopped_o,
    output logic [CNT_W-1:0]  pkt_count_o,
    output logic              timing_err_o
);

    typedef struct packed {
        psched_state_e    state;
        logic [TS_W-1:0]  offset;
        logic [CNT_W-1:0] count;
        logic             err;
    } sched_regs_t;

    sched_regs_t regs_d, regs_q;

    logic [TS_W-1:0] now_w;
    logic            due_w;
    logic            late_w;

    psched_timebase #(.W(TS_W)) u_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .now_o (now_w)
    );

    psched_due_eval #(.W(TS_W)) u_due (
        .now_i    (now_w),
        .ts_i     (in_ts),
        .offset_i (regs_q.offset),
        .thresh_i (cfg_err_thresh),
        .due_o    (due_w),
        .late_o   (late_w)
    );

    always_comb begin
        regs_d    = regs_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        case (regs_q.state)
            ST_IDLE: begin
                if (in_valid) regs_d.state = ST_READY;
            end
            ST_READY: begin
                if (stop_trig) begin
                    regs_d.state = ST_DONE;
                end else if (start_trig) begin
                    regs_d.offset = now_w + TS_W'(1) - in_ts + cfg_start_delay;
                    regs_d.state  = ST_GEN;
                end
            end
            ST_GEN: begin
                if (stop_trig) begin
                    regs_d.state = ST_DONE;
                end else if (in_valid && in_eos) begin
                    in_ready     = 1'b1;
                    regs_d.state = ST_DONE;
                end else if (in_valid && due_w) begin
                    out_valid = 1'b1;
                    in_ready  = out_ready;
                    if (out_ready) begin
                        regs_d.count = regs_q.count + CNT_W'(1);
                        if (late_w) begin
                            regs_d.err   = 1'b1;
                            regs_d.state = ST_ERR;
                        end
                    end
                end
            end
            ST_DONE, ST_ERR: begin
                if (start_trig) begin
                    regs_d.state = ST_IDLE;
                    regs_d.count = '0;
                    regs_d.err   = 1'b0;
                end
            end
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state  <= ST_IDLE;
            regs_q.offset <= '0;
            regs_q.count  <= '0;
            regs_q.err    <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign out_data     = in_data;
    assign state_o      = regs_q.state;
    assign stopped_o    = (regs_q.state == ST_DONE) || (regs_q.state == ST_ERR);
    assign pkt_count_o  = regs_q.count;
    assign timing_err_o = regs_q.err;

endmodule

// File: rtl/psched_checker.sv
`timescale 1ns/1ps
module psched_checker
    import psched_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_trig,
    input logic             stop_trig,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_eos,
    input logic             out_valid,
    input logic             out_ready,
    input logic [2:0]       state_o,
    input logic             stopped_o,
    input logic [CNT_W-1:0] pkt_count_o,
    input logic             timing_err_o
);

    a_r2_no_accept_before_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE || state_o == ST_READY) |-> !in_ready);

    a_r4_release_only_in_gen: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> state_o == ST_GEN);

    a_r5_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> pkt_count_o == CNT_W'($past(pkt_count_o) + 1'b1));

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_err_o && !start_trig) |=> timing_err_o);

    a_r6_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timing_err_o) |-> state_o == ST_ERR);

    a_r8_eos_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_GEN && in_valid && in_eos && in_ready && !stop_trig) |=> state_o == ST_DONE);

    a_r9_stop_done: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == ST_GEN || state_o == ST_READY) && stop_trig) |=> state_o == ST_DONE);

    a_r9_stop_no_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_GEN && stop_trig) |-> !out_valid);

    a_r10_stop_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped_o) |-> ($past(state_o) == ST_GEN || $past(state_o) == ST_READY));

endmodule

bind pkt_playback_sched psched_checker #(.CNT_W(CNT_W)) u_psched_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_trig   (start_trig),
    .stop_trig    (stop_trig),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_eos       (in_eos),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .state_o      (state_o),
    .stopped_o    (stopped_o),
    .pkt_count_o  (pkt_count_o),
    .timing_err_o (timing_err_o)
);

// File: tb/pkt_playback_sched_bench.sv
`timescale 1ns/1ps
module pkt_playback_sched_bench;

    localparam int TS_W   = 64;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic [TS_W-1:0]   cfg_start_delay, cfg_err_thresh;
    logic              start_trig, stop_trig;
    logic              in_valid, in_ready, in_eos;
    logic [TS_W-1:0]   in_ts;
    logic [DATA_W-1:0] in_data, out_data;
    logic              out_valid, out_ready;
    logic [2:0]        state_o;
    logic              stopped_o, timing_err_o;
    logic [CNT_W-1:0]  pkt_count_o;

    pkt_playback_sched #(.TS_W(TS_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_pkt_playback_sched (
        .clk(clk), .rst_n(rst_n),
        .cfg_start_delay(cfg_start_delay), .cfg_err_thresh(cfg_err_thresh),
        .start_trig(start_trig), .stop_trig(stop_trig),
        .in_valid(in_valid), .in_ready(in_ready), .in_ts(in_ts),
        .in_data(in_data), .in_eos(in_eos),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .state_o(state_o), .stopped_o(stopped_o),
        .pkt_count_o(pkt_count_o), .timing_err_o(timing_err_o)
    );

    typedef struct {
        longint            ts;
        logic [DATA_W-1:0] data;
        bit                eos;
    } beat_t;

    beat_t  q[$];
    int     m_state, m_count;
    longint m_time, m_off;
    bit     m_err;
    bit     p_start, p_stop;
    int     stall_left;
    longint delay_cfg, thresh_cfg;
    longint trig_time, first_rel_time, last_late;
    int     n_vec, n_fail;
    bit     finished;

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(longint ts, logic [DATA_W-1:0] d, bit e);
        beat_t b;
        b.ts = ts; b.data = d; b.eos = e;
        q.push_back(b);
    endtask

    // one cycle: drive at the falling edge, compare, advance the model
    task automatic step();
        beat_t  h;
        bit     hv, e_ov, e_ir;
        longint due;
        hv = (q.size() > 0);
        if (hv) h = q[0];
        else begin h.ts = 0; h.data = '0; h.eos = 1'b0; end
        in_valid        = hv;
        in_ts           = TS_W'(h.ts);
        in_data         = h.data;
        in_eos          = h.eos;
        start_trig      = p_start;
        stop_trig       = p_stop;
        out_ready       = (stall_left == 0);
        cfg_start_delay = TS_W'(delay_cfg);
        cfg_err_thresh  = TS_W'(thresh_cfg);
        #1;
        due  = h.ts + m_off;
        e_ov = 1'b0;
        e_ir = 1'b0;
        if (m_state == 2 && !p_stop && hv) begin
            if (h.eos) e_ir = 1'b1;
            else if (m_time >= due) begin e_ov = 1'b1; e_ir = out_ready; end
        end
        chk(state_o == 3'(m_state), "R11 state", longint'(state_o), m_state);
        chk(stopped_o == (m_state == 3 || m_state == 4), "R10 stopped", stopped_o, (m_state == 3 || m_state == 4));
        chk(pkt_count_o == CNT_W'(m_count), "R5 count", pkt_count_o, m_count);
        chk(timing_err_o == m_err, "R6 err flag", timing_err_o, m_err);
        chk(out_valid == e_ov, "R4 out_valid", out_valid, e_ov);
        chk(in_ready == e_ir, "R2 in_ready", in_ready, e_ir);
        if (e_ov) chk(out_data == h.data, "R4 out_data", out_data, h.data);
        case (m_state)
            0: if (hv) m_state = 1;
            1: if (p_stop) m_state = 3;
               else if (p_start) begin
                   m_off = m_time + 1 - h.ts + delay_cfg;
                   trig_time = m_time;
                   m_state = 2;
               end
            2: if (p_stop) m_state = 3;
               else if (hv && h.eos) begin void'(q.pop_front()); m_state = 3; end
               else if (e_ov && out_ready) begin
                   void'(q.pop_front());
                   m_count = (m_count + 1) % (1 << CNT_W);
                   last_late = m_time - due;
                   if (m_count == 1) first_rel_time = m_time;
                   if (last_late > thresh_cfg) begin m_err = 1'b1; m_state = 4; end
               end
            default: if (p_start) begin m_state = 0; m_count = 0; m_err = 1'b0; end
        endcase
        m_time++;
        p_start = 1'b0;
        p_stop  = 1'b0;
        if (stall_left > 0) stall_left--;
        @(negedge clk);
    endtask

    task automatic run_until(int st, int maxc);
        for (int i = 0; i < maxc && m_state != st; i++) step();
        if (m_state != st) chk(1'b0, "watchdog state wait", m_state, st);
    endtask

    task automatic run_until_count(int c, int maxc);
        for (int i = 0; i < maxc && m_count < c; i++) step();
        if (m_count < c) chk(1'b0, "watchdog count wait", m_count, c);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; m_state = 0; m_count = 0; m_time = 0; m_off = 0; m_err = 1'b0;
        p_start = 1'b0; p_stop = 1'b0; stall_left = 0; delay_cfg = 0; thresh_cfg = 2;
        trig_time = 0; first_rel_time = 0; last_late = 0; n_vec = 0; n_fail = 0; finished = 1'b0;
        start_trig = 1'b0; stop_trig = 1'b0; in_valid = 1'b0; in_ts = '0; in_data = '0;
        in_eos = 1'b0; out_ready = 1'b1; cfg_start_delay = '0; cfg_err_thresh = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state checked by the per-cycle compare
        step();
        chk(state_o == 3'd0 && !out_valid, "R1 reset idle", state_o, 0);

        // run 1: zero delay, equal timestamps, end-of-stream
        push(1000, 32'hA1, 0); push(1003, 32'hA2, 0); push(1003, 32'hA3, 0);
        push(1010, 32'hA4, 0); push(0, 32'h0, 1);
        step(); step();
        chk(state_o == 3'd1, "R2 ready on first beat", state_o, 1);
        p_start = 1'b1; step();
        run_until(3, 200);
        chk(first_rel_time == trig_time + 1, "R3 zero-delay first release", first_rel_time, trig_time + 1);
        chk(pkt_count_o == 4, "R8 done after stream", pkt_count_o, 4);

        // run 2: negative timestamps, delay 5, backpressure inside threshold
        p_start = 1'b1; step();
        delay_cfg = 5; thresh_cfg = 3;
        push(-50, 32'hB1, 0); push(-40, 32'hB2, 0); push(0, 32'h0, 1);
        step();
        p_start = 1'b1; step();
        run_until_count(1, 100);
        chk(first_rel_time == trig_time + 6, "R3 delayed first release", first_rel_time, trig_time + 6);
        stall_left = 11;
        run_until(3, 200);
        chk(last_late > 0 && !timing_err_o, "R7 stall adds lateness within limit", last_late, 1);
        chk(pkt_count_o == 2 && state_o == 3'd3, "R12 negative stamps played", pkt_count_o, 2);

        // run 3: stall beyond threshold
        p_start = 1'b1; step();
        delay_cfg = 0; thresh_cfg = 1;
        push(0, 32'hC1, 0); push(2, 32'hC2, 0); push(4, 32'hC3, 0); push(0, 32'h0, 1);
        step();
        p_start = 1'b1; step();
        run_until_count(1, 100);
        stall_left = 8;
        run_until(4, 100);
        chk(timing_err_o == 1'b1, "R6 late packet flagged", timing_err_o, 1);
        step(); step(); step();
        chk(timing_err_o == 1'b1 && stopped_o, "R6 flag sticky", timing_err_o, 1);
        p_start = 1'b1; step();
        chk(pkt_count_o == 0 && !timing_err_o, "R10 rearm clears", pkt_count_o, 0);

        // run 4: stops in Ready and mid-stream with packets pending
        step();
        p_stop = 1'b1; step();
        chk(state_o == 3'd3, "R9 stop in ready", state_o, 3);
        p_start = 1'b1; step();
        step();
        thresh_cfg = 100;
        p_start = 1'b1; step();
        run_until_count(1, 100);
        p_stop = 1'b1; step();
        chk(state_o == 3'd3 && pkt_count_o == 1, "R9 stop mid-stream", pkt_count_o, 1);
        q.delete();
        p_start = 1'b1; step();
        step(); step();
        chk(state_o == 3'd0, "R2 idle without input", state_o, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule